// File: doc/BRIEF.md
# Paged Program Sequencer with Nibble Stack

This block produces the instruction fetch address of a small 4-bit controller. Its program space is 6 pages of 256 steps. The 12-bit address is a 4-bit page above an 8-bit step. The controller's decoder gives the block one command per instruction: advance, jump, call or return. The block also takes an interrupt request with a 3-bit vector index.

The block keeps no return-address storage of its own. A call or an accepted interrupt stores the 12-bit return address as three 4-bit words in the shared 96-word data RAM. A return reads those three words back. Each word takes one clock. While a transfer is in progress the block shows `busy`, holds the fetch address and ignores new commands and interrupts.

The stack pointer starts at 60H and is decremented before each write. It wraps modulo 96. A sticky flag records any write that lands below 10H, because addresses 00H to 0FH belong to the register-pointer area.

Top module: `pgseq_top`

## Requirements
- R1: After a synchronous reset, `fetch_addr` is 100H (page 1, step 00H), `busy` and `stk_err` are low, and the stack pointer is 60H, so the first stack write goes to 5FH.
- R2: With `cmd_op`=0 (advance) accepted while idle, the step field `fetch_addr[7:0]` increments on the next clock. Step FFH rolls over to step 00H of the next page (`fetch_addr[11:8]`), and page 5 step FFH rolls over to 000H.
- R3: With `cmd_op`=1 (jump) accepted while idle, `fetch_addr` equals `cmd_tgt` after the next clock.
- R4: With `cmd_op`=2 (call) accepted while idle, the block writes the return address (the advanced `fetch_addr`) on three consecutive clocks, to stack pointer minus 1, minus 2 and minus 3. The words are written in the order page, step[7:4], step[3:0]. `fetch_addr` becomes `cmd_tgt` on the clock of the third write.
- R5: With `cmd_op`=3 (return) accepted while idle, the block reads the stack pointer, plus 1 and plus 2 on three consecutive clocks. It takes those words as step[3:0], step[7:4] and page, and on the third clock loads `fetch_addr` with the rebuilt address.
- R6: `busy` is high for exactly the three transfer clocks. During them `fetch_addr` holds its value and any command is ignored.
- R7: An interrupt request seen while idle wins over a command issued in the same cycle, and that command is dropped. The block pushes the current `fetch_addr` as in R4 and then loads page 1 with step 01H plus `irq_vec`.
- R8: Stack addresses wrap modulo 96. A decrement from 00H goes to 5FH, and an increment from 5FH goes to 00H.
- R9: `stk_err` goes high when a stack write address falls below 10H. It stays high until reset.
- R10: `ram_addr` is always below 96 when `ram_we` or `ram_re` is high, and the two are never high together.
- R11: An interrupt request raised during a transfer is not taken until the block is idle again. It is then accepted and saves the address that the transfer left in `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Command valid for this cycle |
| cmd_op | input | 2 | 0 advance, 1 jump, 2 call, 3 return |
| cmd_tgt | input | 12 | Jump or call target {page, step} |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | 3 | Interrupt vector index |
| ram_rdata | input | 4 | Data RAM read word (combinational read) |
| ram_we | output | 1 | Data RAM write strobe |
| ram_re | output | 1 | Data RAM read strobe |
| ram_addr | output | 7 | Data RAM word address |
| ram_wdata | output | 4 | Data RAM write word |
| fetch_addr | output | 12 | Program fetch address {page, step} |
| busy | output | 1 | Stack transfer in progress |
| stk_err | output | 1 | Sticky stack-floor violation |

## Verification
The advance path is swept over all 1536 addresses, so the rollover inside a page and the wrap from page 5 to page 0 are both exercised. Jumps go to the first, middle and last step of every page. Nested calls to 26 levels, followed by matching returns, confirm that the nibble order and the push/pop addresses mirror each other. Extending the nesting to 33 levels shows the exact call that trips the floor flag and the one whose write wraps from 00H to 5FH. Every vector index is taken while an advance command is held in the same cycle, which separates interrupt priority from command handling. A request raised in the middle of a call separates deferral from loss of the request.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
    localparam int PAGE_W        = 4;
    localparam int STEP_W        = 8;
    localparam int NIB_W         = 4;
    localparam int ADDR_W        = PAGE_W + STEP_W;
    localparam int NNIB          = ADDR_W / NIB_W;
    localparam int VEC_W         = 3;
    localparam int NPAGES_DEF    = 6;
    localparam int RAM_WORDS_DEF = 96;
    localparam int SP_FLOOR_DEF  = 16;
    localparam int RAM_AW_DEF    = $clog2(RAM_WORDS_DEF + 1);

    localparam logic [PAGE_W-1:0] BOOT_PAGE = PAGE_W'(1);
    localparam logic [STEP_W-1:0] VEC_STEP0 = STEP_W'(1);

    typedef enum logic [1:0] {
        OP_NEXT = 2'd0,
        OP_JUMP = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PUSH0, ST_PUSH1, ST_PUSH2, ST_POP0, ST_POP1, ST_POP2
    } st_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [STEP_W-1:0] step;
    } paddr_t;

    localparam paddr_t BOOT_ADDR = '{page: BOOT_PAGE, step: '0};

    function automatic paddr_t vec_target(input logic [VEC_W-1:0] v);
        paddr_t a;
        a.page = BOOT_PAGE;
        a.step = VEC_STEP0 + STEP_W'(v);
        return a;
    endfunction
endpackage

// File: rtl/pgseq_incr.sv
module pgseq_incr
    import pgseq_pkg::*;
#(
    parameter int NPAGES = NPAGES_DEF
) (
    input  paddr_t cur,
    output paddr_t nxt
);
    localparam logic [PAGE_W-1:0] LASTP = PAGE_W'(NPAGES - 1);

    always_comb begin
        nxt      = cur;
        nxt.step = cur.step + STEP_W'(1);
        if (cur.step == '1) begin
            nxt.page = (cur.page >= LASTP) ? '0 : cur.page + PAGE_W'(1);
        end
    end
endmodule

// File: rtl/pgseq_nibsel.sv
module pgseq_nibsel
    import pgseq_pkg::*;
(
    input  paddr_t                      val,
    input  logic [$clog2(NNIB)-1:0]     idx,
    output logic [NIB_W-1:0]            nib
);
    logic [ADDR_W-1:0] flat;
    logic [NIB_W-1:0]  parts [NNIB];

    assign flat = val;

    // part 0 is the most significant nibble (the page)
    for (genvar g = 0; g < NNIB; g++) begin : g_part
        assign parts[g] = flat[ADDR_W-1-g*NIB_W -: NIB_W];
    end

    always_comb begin
        nib = '0;
        for (int i = 0; i < NNIB; i++) begin
            if (int'(idx) == i) nib = parts[i];
        end
    end
endmodule

// File: rtl/pgseq_sp.sv
module pgseq_sp #(
    parameter int WORDS = 96,
    parameter int FLOOR = 16,
    parameter int AW    = $clog2(WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec,
    input  logic          inc,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          err
);
    localparam logic [AW-1:0] TOP  = AW'(WORDS);
    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);
    localparam logic [AW-1:0] FLR  = AW'(FLOOR);
    localparam logic [AW-1:0] ONE  = AW'(1);

    logic [AW-1:0] sp_q;
    logic [AW-1:0] up;

    always_comb begin
        rd_addr = (sp_q >= TOP) ? sp_q - TOP : sp_q;
        wr_addr = (rd_addr == '0) ? LAST : rd_addr - ONE;
        up      = (rd_addr == LAST) ? '0 : rd_addr + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= TOP;
            err  <= 1'b0;
        end else if (dec) begin
            sp_q <= wr_addr;
            if (wr_addr < FLR) err <= 1'b1;
        end else if (inc) begin
            sp_q <= up;
        end
    end
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
    import pgseq_pkg::*;
#(
    parameter int NPAGES    = NPAGES_DEF,
    parameter int RAM_WORDS = RAM_WORDS_DEF,
    parameter int SP_FLOOR  = SP_FLOOR_DEF,
    parameter int RAM_AW    = $clog2(RAM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_go,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_tgt,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [NIB_W-1:0]  ram_rdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [NIB_W-1:0]  ram_wdata,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              busy,
    output logic              stk_err
);
    st_e               st_q;
    paddr_t            pc_q, pc_inc, save_q, dest_q;
    logic [NIB_W-1:0]  lo_q, hi_q;
    logic [RAM_AW-1:0] wr_addr, rd_addr;
    logic [$clog2(NNIB)-1:0] nib_idx;
    op_e               op;

    assign op = op_e'(cmd_op);

    pgseq_incr #(.NPAGES(NPAGES)) u_incr (
        .cur (pc_q),
        .nxt (pc_inc)
    );

    pgseq_nibsel u_nib (
        .val (save_q),
        .idx (nib_idx),
        .nib (ram_wdata)
    );

    pgseq_sp #(.WORDS(RAM_WORDS), .FLOOR(SP_FLOOR), .AW(RAM_AW)) u_sp (
        .clk     (clk),
        .rst     (rst),
        .dec     (ram_we),
        .inc     (ram_re),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .err     (stk_err)
    );

    always_comb begin
        ram_we  = (st_q == ST_PUSH0) || (st_q == ST_PUSH1) || (st_q == ST_PUSH2);
        ram_re  = (st_q == ST_POP0)  || (st_q == ST_POP1)  || (st_q == ST_POP2);
        ram_addr = ram_we ? wr_addr : rd_addr;
        unique case (st_q)
            ST_PUSH1: nib_idx = 2'd1;
            ST_PUSH2: nib_idx = 2'd2;
            default:  nib_idx = 2'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pc_q   <= BOOT_ADDR;
            save_q <= '0;
            dest_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (irq_req) begin
                        save_q <= pc_q;
                        dest_q <= vec_target(irq_vec);
                        st_q   <= ST_PUSH0;
                    end else if (cmd_go) begin
                        unique case (op)
                            OP_NEXT: pc_q <= pc_inc;
                            OP_JUMP: pc_q <= paddr_t'(cmd_tgt);
                            OP_CALL: begin
                                save_q <= pc_inc;
                                dest_q <= paddr_t'(cmd_tgt);
                                st_q   <= ST_PUSH0;
                            end
                            OP_RET:  st_q <= ST_POP0;
                        endcase
                    end
                end
                ST_PUSH0: st_q <= ST_PUSH1;
                ST_PUSH1: st_q <= ST_PUSH2;
                ST_PUSH2: begin
                    pc_q <= dest_q;
                    st_q <= ST_IDLE;
                end
                ST_POP0: begin
                    lo_q <= ram_rdata;
                    st_q <= ST_POP1;
                end
                ST_POP1: begin
                    hi_q <= ram_rdata;
                    st_q <= ST_POP2;
                end
                ST_POP2: begin
                    pc_q <= paddr_t'({ram_rdata, hi_q, lo_q});
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign fetch_addr = pc_q;
    assign busy       = (st_q != ST_IDLE);
endmodule

// File: rtl/pgseq_chk.sv
module pgseq_chk
    import pgseq_pkg::*;
#(
    parameter int RAM_WORDS = RAM_WORDS_DEF,
    parameter int RAM_AW    = RAM_AW_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_req,
    input logic              busy,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              ram_we,
    input logic              ram_re,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              stk_err
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (fetch_addr == ADDR_W'(BOOT_ADDR) && !busy && !stk_err));

    // R6
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(fetch_addr));

    // R10
    ram_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we || ram_re) |-> (ram_addr < RAM_AW'(RAM_WORDS)));

    // R10
    ram_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ram_we && ram_re));

    // R4
    push_descend_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |->
        ram_addr == (($past(ram_addr) == '0) ? RAM_AW'(RAM_WORDS - 1)
                                               : $past(ram_addr) - RAM_AW'(1)));

    // R5
    pop_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_re && $past(ram_re)) |->
        ram_addr == (($past(ram_addr) == RAM_AW'(RAM_WORDS - 1)) ? '0
                                               : $past(ram_addr) + RAM_AW'(1)));

    // R7
    irq_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && irq_req) |=> (busy && ram_we));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err);
endmodule

bind pgseq_top pgseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .busy       (busy),
    .fetch_addr (fetch_addr),
    .ram_we     (ram_we),
    .ram_re     (ram_re),
    .ram_addr   (ram_addr),
    .stk_err    (stk_err)
);

// File: tb/sim_pgseq_top.sv
module sim_pgseq_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_go;
    logic [1:0]  cmd_op;
    logic [11:0] cmd_tgt;
    logic        irq_req;
    logic [2:0]  irq_vec;
    logic [3:0]  ram_rdata;
    logic        ram_we, ram_re, busy, stk_err;
    logic [6:0]  ram_addr;
    logic [3:0]  ram_wdata;
    logic [11:0] fetch_addr;

    int n_chk = 0;
    int n_bad = 0;

    logic [3:0]  mem [0:95];
    int          wn, rn;
    logic [6:0]  wa [0:7];
    logic [3:0]  wd [0:7];
    logic [6:0]  ra [0:7];

    int          exp_sp;
    bit          exp_err;
    logic [11:0] stk [0:63];
    int          depth;

    pgseq_top u0 (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_tgt(cmd_tgt),
        .irq_req(irq_req), .irq_vec(irq_vec), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .fetch_addr(fetch_addr), .busy(busy), .stk_err(stk_err)
    );

    always #(CLK_P/2) clk = ~clk;

    assign ram_rdata = (ram_addr < 7'd96) ? mem[ram_addr] : 4'h0;

    always @(posedge clk) begin
        if (ram_we) begin
            if (ram_addr < 7'd96) mem[ram_addr] <= ram_wdata;
            if (wn < 8) begin wa[wn] = ram_addr; wd[wn] = ram_wdata; end
            wn = wn + 1;
        end
        if (ram_re) begin
            if (rn < 8) ra[rn] = ram_addr;
            rn = rn + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] nxt(input logic [11:0] a);
        int lin;
        lin = (int'(a[11:8]) * 256 + int'(a[7:0]) + 1) % 1536;
        return {4'(lin / 256), 8'(lin % 256)};
    endfunction

    task automatic do_reset();
        rst = 1; cmd_go = 0; cmd_op = 0; cmd_tgt = 0; irq_req = 0; irq_vec = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        exp_sp = 0; exp_err = 0; depth = 0;
    endtask

    task automatic do_jump(input logic [11:0] t);
        cmd_go = 1; cmd_op = 2'd1; cmd_tgt = t;
        @(negedge clk);
        cmd_go = 0;
        chk(fetch_addr == t, "R3", fetch_addr, t);
    endtask

    // call (irq=0) or interrupt (irq=1); optional stray command during busy
    task automatic do_push(input logic [11:0] t, input bit stray, input bit irq, input logic [2:0] v);
        logic [11:0] pre, ret, dst;
        int s0, a;
        string at;
        pre = fetch_addr;
        ret = irq ? pre : nxt(pre);
        dst = irq ? (12'h101 + 12'(v)) : t;
        s0 = exp_sp; wn = 0; rn = 0;
        if (irq) begin
            irq_req = 1; irq_vec = v; cmd_go = 1; cmd_op = 2'd0;
        end else begin
            cmd_go = 1; cmd_op = 2'd2; cmd_tgt = t;
        end
        @(negedge clk);
        irq_req = 0;
        if (stray) begin cmd_go = 1; cmd_op = 2'd1; cmd_tgt = 12'h0AA; end
        else cmd_go = 0;
        for (int i = 0; i < 3; i++) begin
            chk(busy && fetch_addr == pre, "R6", {busy, 19'd0, fetch_addr}, {1'b1, 19'd0, pre});
            @(negedge clk);
        end
        cmd_go = 0;
        chk(!busy, "R6", busy, 0);
        chk(fetch_addr == dst, irq ? "R7" : "R4", fetch_addr, dst);
        chk(wn == 3, "R4", wn, 3);
        chk(rn == 0, "R10", rn, 0);
        at = (s0 < 3) ? "R8" : "R4";
        for (int i = 0; i < 3; i++) begin
            a = (s0 + 95 - i) % 96;
            if (a < 16) exp_err = 1;
            chk(wa[i] == 7'(a), at, wa[i], a);
            chk(wd[i] == ret[11-4*i -: 4], "R4", wd[i], ret[11-4*i -: 4]);
        end
        exp_sp = (s0 + 93) % 96;
        chk(stk_err == exp_err, "R9", stk_err, exp_err);
        if (depth < 64) stk[depth] = ret;
        depth++;
    endtask

    task automatic do_ret();
        logic [11:0] pre, ex;
        int s0;
        pre = fetch_addr;
        depth--;
        ex = stk[depth];
        s0 = exp_sp; rn = 0; wn = 0;
        cmd_go = 1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_go = 0;
        for (int i = 0; i < 3; i++) begin
            chk(busy && fetch_addr == pre, "R6", fetch_addr, pre);
            @(negedge clk);
        end
        chk(fetch_addr == ex, "R5", fetch_addr, ex);
        chk(rn == 3 && wn == 0, "R5", rn, 3);
        for (int i = 0; i < 3; i++)
            chk(ra[i] == 7'((s0 + i) % 96), "R5", ra[i], (s0 + i) % 96);
        exp_sp = (s0 + 3) % 96;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] e, t, pre;
        for (int i = 0; i < 96; i++) mem[i] = 4'h0;
        wn = 0; rn = 0;
        do_reset();

        // R1 reset state
        chk(fetch_addr == 12'h100, "R1", fetch_addr, 12'h100);
        chk(!busy && !stk_err && !ram_we, "R1", {busy, stk_err, ram_we}, 0);

        // R1: first push after reset lands at 5FH (checked inside do_push)
        do_push(12'h234, 0, 0, 0);
        chk(wa[0] == 7'h5F, "R1", wa[0], 7'h5F);
        do_ret();

        // R3 jumps to first, middle and last step of every page
        for (int p = 0; p < 6; p++) begin
            do_jump({4'(p), 8'h00});
            do_jump({4'(p), 8'h7F});
            do_jump({4'(p), 8'hFF});
        end

        // R2 full sweep of sequential advance
        do_jump(12'h000);
        e = 12'h000;
        cmd_go = 1; cmd_op = 2'd0;
        for (int i = 0; i < 1536; i++) begin
            @(negedge clk);
            e = nxt(e);
            chk(fetch_addr == e, "R2", fetch_addr, e);
        end
        cmd_go = 0;
        chk(fetch_addr == 12'h000, "R2", fetch_addr, 12'h000);

        // R4/R5/R6 nesting to 26 levels, then unwind
        for (int k = 1; k <= 26; k++)
            do_push({4'(k % 6), 8'((k * 37) % 256)}, k[0], 0, 0);
        chk(!stk_err, "R9", stk_err, 0);
        for (int k = 1; k <= 26; k++) do_ret();

        // R9 floor crossing and R8 wrap across 33 nested calls
        for (int k = 1; k <= 33; k++) begin
            do_push({4'(k % 6), 8'((k * 53) % 256)}, 0, 0, 0);
            if (k == 26) chk(!stk_err, "R9", stk_err, 0);
            if (k == 27) chk(stk_err, "R9", stk_err, 1);
            if (k == 33) chk(wa[0] == 7'h5F, "R8", wa[0], 7'h5F);
        end
        chk(stk_err, "R9", stk_err, 1);

        do_reset();
        chk(fetch_addr == 12'h100 && !stk_err, "R1", {stk_err, fetch_addr}, 12'h100);

        // R7 every vector, with a competing advance command
        for (int v = 0; v < 8; v++) begin
            do_jump({4'(v % 6), 8'(v * 29 + 3)});
            pre = fetch_addr;
            do_push(12'h000, 0, 1, 3'(v));
            do_ret();
            chk(fetch_addr == pre, "R7", fetch_addr, pre);
        end

        // R11 request raised mid-transfer is deferred
        do_jump(12'h3C0);
        pre = fetch_addr;
        t = 12'h2F0;
        cmd_go = 1; cmd_op = 2'd2; cmd_tgt = t;
        @(negedge clk);
        cmd_go = 0;
        @(negedge clk);
        irq_req = 1; irq_vec = 3'd3;
        @(negedge clk);
        @(negedge clk);
        chk(fetch_addr == t && !busy, "R11", fetch_addr, t);
        stk[depth] = nxt(pre); depth++;
        exp_sp = (exp_sp + 93) % 96;
        wn = 0;
        @(negedge clk);
        irq_req = 0;
        chk(busy, "R11", busy, 1);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(fetch_addr == 12'h104, "R11", fetch_addr, 12'h104);
        chk(wn == 3 && wd[0] == t[11:8] && wd[1] == t[7:4] && wd[2] == t[3:0], "R11",
            {wd[0], wd[1], wd[2]}, t);
        stk[depth] = t; depth++;
        exp_sp = (exp_sp + 93) % 96;
        do_ret();
        do_ret();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule